// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Retry

This block sends characters, one at a time, over the single open-drain data line of an ISO 7816 style smart card link. Each character goes out as a frame with a low start bit, eight data bits (least significant first) and an even parity bit. After the parity bit the transmitter releases the line for one bit time. During that time the card may pull the line low to reject the character. A rejected character is sent again from an internal copy, with no help from software. Only a frame the card accepts ends the character.

Software writes a character into a one-deep data register. An empty flag shows when that register may take the next character. A transmit-end flag reports that a character was accepted. A sticky error flag reports that the card rejected at least one frame. Each flag has an enable input that gates it onto an interrupt request. Bit timing comes from an oversampling tick input, with a fixed number of ticks per bit time. The card's receive path, the card clock and the answer-to-reset sequence are handled elsewhere.

Top module: `card_tx_retry`

## Requirements
- R1: A frame is line-low start, then D0..D7 least significant first, then a parity bit chosen so that D0..D7 plus parity hold an even number of ones. The block drives a 0 by raising `line_pull_low`. It drives a 1 by releasing the line.
- R2: `line_pull_low` stays low through the error slot (bit time 10 after the start edge) and through the two guard bit times that follow. The next frame's start edge comes 13 bit times (13*OSR ticks) after the previous start edge.
- R3: The line is sampled in the middle of the error slot. A low level sets `err_flag` to 1. A high level leaves `err_flag` unchanged, so it stays 0 when it was clear.
- R4: `irq_err` is 1 exactly when `err_flag` is 1 and `err_irq_en` is 1. It follows a change of the enable within one clock.
- R5: After a rejected frame the same character is sent again, bit for bit, as often as the card rejects it. `tend` is not set at the end of a rejected frame.
- R6: `tend` becomes 1 at the end of the last guard bit of a frame that was not rejected. `irq_tx` is 1 exactly when `tend` is 1 and `tx_irq_en` is 1.
- R7: A write (`wr_en`) clears `tdre` and `tend` on the next clock. `tdre` returns to 1 when the character moves into the shift stage, one clock later when the transmitter is idle.
- R8: A character written while a retry is pending stays in the data register, with `tdre` at 0. It is sent only after the held character has gone through unrejected.
- R9: `err_clr` clears `err_flag`. The retry decision depends only on the current frame's own error sample, so an uncleared `err_flag` causes no extra retry.
- R10: After reset, `tdre` and `tend` are 1, `err_flag`, `irq_err` and `irq_tx` are 0, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | Oversampling tick, OSR ticks per bit time |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Character to send |
| err_clr | input | 1 | Clears the error flag |
| err_irq_en | input | 1 | Enables the error interrupt |
| tx_irq_en | input | 1 | Enables the transmit-end interrupt |
| line_in | input | 1 | Level seen on the shared data line |
| line_pull_low | output | 1 | Open-drain enable, 1 pulls the line low |
| tdre | output | 1 | Data register empty |
| tend | output | 1 | Last character accepted, transmitter done |
| err_flag | output | 1 | Sticky card-rejection flag |
| irq_err | output | 1 | Error interrupt request |
| irq_tx | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case to reach is a new character written while a rejected character waits for its retry. The write must land in the narrow window after the error sample and before the retry starts. The bench's card model tracks the tick count from each start edge. It pulls the line low across the error slot of chosen frames. The write is timed off the moment the model has finished sampling a rejected frame. Back-to-back rejections are forced the same way. The bench also leaves the sticky error flag uncleared before a clean frame, which shows that the flag does not cause a retry.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } sctx_state_e;

  // index of the last guard bit time: start + data + parity + slot + guards
  function automatic int frame_last_idx(input int data_w, input int guard_bits);
    return data_w + 2 + guard_bits;
  endfunction

endpackage

// File: rtl/sctx_bit_timer.sv
module sctx_bit_timer #(
  parameter int OSR   = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  output logic [IDX_W-1:0] bit_idx,
  output logic             mid_pulse,
  output logic             bit_end
);
  localparam int OS_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [OS_W-1:0] HALF_C = OS_W'(OSR / 2);
  localparam logic [OS_W-1:0] TOP_C  = OS_W'(OSR - 1);

  logic [OS_W-1:0] os_cnt;

  assign mid_pulse = run && tick && (os_cnt == HALF_C);
  assign bit_end   = run && tick && (os_cnt == TOP_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      os_cnt  <= '0;
      bit_idx <= '0;
    end else if (restart) begin
      os_cnt  <= '0;
      bit_idx <= '0;
    end else if (run && tick) begin
      if (os_cnt == TOP_C) begin
        os_cnt  <= '0;
        bit_idx <= bit_idx + 1'b1;
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sctx_line_drv.sv
module sctx_line_drv #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] char_q,
  output logic              line_pull_low
);
  localparam logic [IDX_W-1:0] PAR_C = IDX_W'(DATA_W + 1);

  logic level;

  always_comb begin
    level = 1'b1;
    if (active) begin
      if (bit_idx == '0) begin
        level = 1'b0;
      end else if (bit_idx == PAR_C) begin
        level = ^char_q;
      end else begin
        for (int i = 0; i < DATA_W; i++) begin
          if (bit_idx == IDX_W'(i + 1)) level = char_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_pull_low <= 1'b0;
    else     line_pull_low <= ~level;
  end

endmodule

// File: rtl/sctx_flags.sv
module sctx_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic load,
  input  logic err_set,
  input  logic err_clr,
  input  logic tend_set,
  input  logic err_irq_en,
  input  logic tx_irq_en,
  output logic tdre,
  output logic tend,
  output logic err_flag,
  output logic irq_err,
  output logic irq_tx
);
  logic tdre_d, tend_d, err_d;

  always_comb begin
    tdre_d = wr_en ? 1'b0 : (load ? 1'b1 : tdre);
    tend_d = tend_set ? 1'b1 : (wr_en ? 1'b0 : tend);
    err_d  = err_set ? 1'b1 : (err_clr ? 1'b0 : err_flag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tdre     <= 1'b1;
      tend     <= 1'b1;
      err_flag <= 1'b0;
      irq_err  <= 1'b0;
      irq_tx   <= 1'b0;
    end else begin
      tdre     <= tdre_d;
      tend     <= tend_d;
      err_flag <= err_d;
      irq_err  <= err_irq_en & err_d;
      irq_tx   <= tx_irq_en & tend_d;
    end
  end

endmodule

// File: rtl/card_tx_retry.sv
module card_tx_retry
  import sctx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int GUARD_BITS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              etu_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  input  logic              err_irq_en,
  input  logic              tx_irq_en,
  input  logic              line_in,
  output logic              line_pull_low,
  output logic              tdre,
  output logic              tend,
  output logic              err_flag,
  output logic              irq_err,
  output logic              irq_tx
);
  localparam int SLOT_IDX = DATA_W + 2;
  localparam int LAST_IDX = frame_last_idx(DATA_W, GUARD_BITS);
  localparam int IDX_W    = $clog2(LAST_IDX + 2);
  localparam logic [IDX_W-1:0] SLOT_C = IDX_W'(SLOT_IDX);
  localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LAST_IDX);

  sctx_state_e       state_q, state_d;
  logic [DATA_W-1:0] tdr_q, cur_q;
  logic              frame_err_q, frame_err_d;
  logic [IDX_W-1:0]  bit_idx;
  logic              mid_pulse, bit_end;
  logic              load, retry, restart, err_set, tend_set, frame_done;
  logic              line_seen, quiet_zone;

  // line input synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= line_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      end
    end
  endgenerate
  assign line_seen = sync_q[SYNC_STAGES-1];

  sctx_bit_timer #(.OSR(OSR), .IDX_W(IDX_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .run      (state_q == ST_FRAME),
    .tick     (etu_tick),
    .bit_idx  (bit_idx),
    .mid_pulse(mid_pulse),
    .bit_end  (bit_end)
  );

  assign err_set    = (state_q == ST_FRAME) && mid_pulse && (bit_idx == SLOT_C) && !line_seen;
  assign frame_done = (state_q == ST_FRAME) && bit_end && (bit_idx == LAST_C);
  assign quiet_zone = (state_q == ST_IDLE) || (bit_idx >= SLOT_C);

  always_comb begin
    load     = 1'b0;
    retry    = 1'b0;
    tend_set = 1'b0;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!tdre) begin
          load    = 1'b1;
          state_d = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (frame_done) begin
          if (frame_err_q) begin
            retry = 1'b1;
          end else begin
            tend_set = 1'b1;
            if (!tdre) load = 1'b1;
            else       state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    restart     = load | retry;
    frame_err_d = restart ? 1'b0 : (err_set ? 1'b1 : frame_err_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      frame_err_q <= 1'b0;
      tdr_q       <= '0;
      cur_q       <= '0;
    end else begin
      state_q     <= state_d;
      frame_err_q <= frame_err_d;
      if (wr_en) tdr_q <= wr_data;
      if (load)  cur_q <= tdr_q;
    end
  end

  sctx_line_drv #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_drv (
    .clk          (clk),
    .rst          (rst),
    .active       (state_q == ST_FRAME),
    .bit_idx      (bit_idx),
    .char_q       (cur_q),
    .line_pull_low(line_pull_low)
  );

  sctx_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .load      (load),
    .err_set   (err_set),
    .err_clr   (err_clr),
    .tend_set  (tend_set),
    .err_irq_en(err_irq_en),
    .tx_irq_en (tx_irq_en),
    .tdre      (tdre),
    .tend      (tend),
    .err_flag  (err_flag),
    .irq_err   (irq_err),
    .irq_tx    (irq_tx)
  );

endmodule

// File: rtl/sctx_checker.sv
module sctx_checker (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic tdre,
  input logic tend,
  input logic err_flag,
  input logic irq_err,
  input logic irq_tx,
  input logic line_pull_low,
  input logic line_seen,
  input logic quiet_zone,
  input logic frame_err
);

  // R4: error request only with the flag set
  a_r4_irq_needs_err: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> err_flag);

  // R6: transmit-end request only with the flag set
  a_r6_irq_needs_tend: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> tend);

  // R7: a write empties nothing, it fills the data register
  a_r7_write_clears_tdre: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tdre);

  // R5: a rejected frame never raises transmit-end
  a_r5_no_tend_on_reject: assert property (@(posedge clk) disable iff (rst)
    $rose(tend) |-> !$past(frame_err));

  // R2: line released in the error slot and guard time
  a_r2_released_in_slot: assert property (@(posedge clk) disable iff (rst)
    $past(quiet_zone) |-> !line_pull_low);

  // R3: error flag rises only after a low line sample
  a_r3_err_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> !$past(line_seen));

endmodule

bind card_tx_retry sctx_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .tdre         (tdre),
  .tend         (tend),
  .err_flag     (err_flag),
  .irq_err      (irq_err),
  .irq_tx       (irq_tx),
  .line_pull_low(line_pull_low),
  .line_seen    (line_seen),
  .quiet_zone   (quiet_zone),
  .frame_err    (frame_err_q)
);

// File: tb/card_tx_retry_tb.sv
module card_tx_retry_tb;
  localparam int OSR  = 4;
  localparam int TDIV = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       etu_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       err_clr = 1'b0;
  logic       err_irq_en = 1'b0;
  logic       tx_irq_en = 1'b0;
  logic       card_low = 1'b0;
  logic       line_in;
  logic       line_pull_low, tdre, tend, err_flag, irq_err, irq_tx;

  assign line_in = ~(line_pull_low | card_low);

  card_tx_retry #(.DATA_W(8), .OSR(OSR), .GUARD_BITS(2), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .etu_tick(etu_tick), .wr_en(wr_en), .wr_data(wr_data),
    .err_clr(err_clr), .err_irq_en(err_irq_en), .tx_irq_en(tx_irq_en),
    .line_in(line_in), .line_pull_low(line_pull_low), .tdre(tdre), .tend(tend),
    .err_flag(err_flag), .irq_err(irq_err), .irq_tx(irq_tx)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int div     = 0;
  int tick_cnt = 0;

  always @(negedge clk) begin
    if (div == TDIV - 1) begin div = 0; etu_tick = 1'b1; end
    else begin div = div + 1; etu_tick = 1'b0; end
  end
  always @(posedge clk) if (etu_tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] c);
    return {^c, c, 1'b0};
  endfunction

  // card model: records each frame seen on the line
  int         fr = 0;
  logic [9:0] fbits [32];
  int         fbase [32];
  logic       ferr [32], firq [32], ftend_s [32], ftend_m [32], fslot [32], ftdre_m [32];
  bit         inj [32];

  task automatic wait_c(input int base, input int n);
    while (tick_cnt - base < n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) inj[i] = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && line_in === 1'b0) begin
        automatic int base = tick_cnt;
        automatic int k = fr % 32;
        fbase[k] = base;
        for (int b = 0; b < 10; b++) begin
          wait_c(base, b * OSR + OSR / 2);
          fbits[k][b] = line_in;
          if (b == 0) ftend_s[k] = tend;
        end
        wait_c(base, 10 * OSR);
        if (inj[k]) card_low = 1'b1;
        wait_c(base, 10 * OSR + 2);
        fslot[k] = line_pull_low;
        wait_c(base, 11 * OSR);
        card_low = 1'b0;
        ferr[k] = err_flag;
        firq[k] = irq_err;
        wait_c(base, 12 * OSR + 2);
        ftend_m[k] = tend;
        ftdre_m[k] = tdre;
        fr = fr + 1;
      end
    end
  end

  task automatic send(input logic [7:0] c);
    @(negedge clk); wr_en = 1'b1; wr_data = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    while (fr < n) @(negedge clk);
    repeat (16 * OSR * TDIV) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tdre == 1'b1,          "R10 tdre", tdre, 1);
    chk(tend == 1'b1,          "R10 tend", tend, 1);
    chk(err_flag == 1'b0,      "R10 err_flag", err_flag, 0);
    chk(irq_err == 1'b0 && irq_tx == 1'b0, "R10 irqs", {irq_err, irq_tx}, 0);
    chk(line_pull_low == 1'b0, "R10 line released", line_pull_low, 0);
  endtask

  task automatic t_basic();
    automatic int k = fr;
    err_irq_en = 1'b1; tx_irq_en = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk); wr_en = 1'b0;
    chk(tdre == 1'b0 && tend == 1'b0, "R7 write clears tdre/tend", {tdre, tend}, 0);
    @(negedge clk);
    chk(tdre == 1'b1, "R7 tdre on load", tdre, 1);
    settle(k + 1);
    chk(fbits[k] == frame_of(8'hA5), "R1 frame bits A5", fbits[k], frame_of(8'hA5));
    chk(ferr[k] == 1'b0 && err_flag == 1'b0, "R3 no error stays clear", err_flag, 0);
    chk(fslot[k] == 1'b0, "R2 released in slot", fslot[k], 0);
    chk(ftend_m[k] == 1'b0, "R6 tend not before frame end", ftend_m[k], 0);
    chk(tend == 1'b1 && irq_tx == 1'b1, "R6 tend and irq_tx", {tend, irq_tx}, 3);
    chk(irq_err == 1'b0, "R4 no error request", irq_err, 0);
  endtask

  task automatic t_retry();
    automatic int k = fr;
    automatic int gap;
    inj[k % 32] = 1'b1;
    send(8'h3C);
    settle(k + 2);
    gap = fbase[(k + 1) % 32] - fbase[k % 32];
    chk(ferr[k % 32] == 1'b1, "R3 error sampled", ferr[k % 32], 1);
    chk(firq[k % 32] == 1'b1, "R4 irq_err with enable", firq[k % 32], 1);
    chk(fslot[k % 32] == 1'b0, "R2 released while card drives", fslot[k % 32], 0);
    chk(ftend_s[(k + 1) % 32] == 1'b0, "R5 no tend after reject", ftend_s[(k + 1) % 32], 0);
    chk(fbits[(k + 1) % 32] == frame_of(8'h3C), "R5 resent bits", fbits[(k + 1) % 32], frame_of(8'h3C));
    chk(gap >= 13 * OSR - 1 && gap <= 13 * OSR + 1, "R2 frame spacing", gap, 13 * OSR);
    chk(tend == 1'b1, "R6 tend after clean retry", tend, 1);
    chk(err_flag == 1'b1, "R9 flag sticky", err_flag, 1);
    pulse_clr();
    chk(err_flag == 1'b0 && irq_err == 1'b0, "R9 err_clr", {err_flag, irq_err}, 0);
  endtask

  task automatic t_gating();
    automatic int k = fr;
    err_irq_en = 1'b0; tx_irq_en = 1'b0;
    inj[k % 32] = 1'b1;
    send(8'hC3);
    settle(k + 2);
    chk(err_flag == 1'b1 && irq_err == 1'b0, "R4 irq_err gated off", {err_flag, irq_err}, 2);
    chk(tend == 1'b1 && irq_tx == 1'b0, "R6 irq_tx gated off", {tend, irq_tx}, 2);
    err_irq_en = 1'b1; tx_irq_en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq_err == 1'b1 && irq_tx == 1'b1, "R4 R6 enables raise requests", {irq_err, irq_tx}, 3);
  endtask

  task automatic t_pending();
    automatic int k = fr;
    inj[k % 32] = 1'b1;
    send(8'h81);
    while (fr < k + 1) @(negedge clk);
    send(8'h7E);
    settle(k + 3);
    chk(fbits[(k + 1) % 32] == frame_of(8'h81), "R8 held char resent first", fbits[(k + 1) % 32], frame_of(8'h81));
    chk(ftdre_m[(k + 1) % 32] == 1'b0, "R8 tdre low while held", ftdre_m[(k + 1) % 32], 0);
    chk(fbits[(k + 2) % 32] == frame_of(8'h7E), "R9 sticky flag no extra retry", fbits[(k + 2) % 32], frame_of(8'h7E));
    chk(ftdre_m[(k + 2) % 32] == 1'b1, "R7 tdre after move", ftdre_m[(k + 2) % 32], 1);
    pulse_clr();
  endtask

  task automatic t_double();
    automatic int k = fr;
    inj[k % 32] = 1'b1; inj[(k + 1) % 32] = 1'b1;
    send(8'h00);
    settle(k + 3);
    chk(fbits[(k + 1) % 32] == frame_of(8'h00) && fbits[(k + 2) % 32] == frame_of(8'h00),
        "R5 second retry same char", fbits[(k + 2) % 32], frame_of(8'h00));
    chk(ftend_s[(k + 2) % 32] == 1'b0, "R5 tend low after two rejects", ftend_s[(k + 2) % 32], 0);
    chk(tend == 1'b1, "R6 tend at last", tend, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_retry();
    t_gating();
    t_pending();
    t_double();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule